// File: doc/BRIEF.md
# Thermometer Operation Sequencer

This block sits behind the byte receiver of a single-wire bus slave. It receives whole function-command bytes with a one-cycle valid strobe. It starts and times the long operations that three of those codes request.

- A temperature conversion. Its length follows the two resolution-select bits.
- A copy of the user scratchpad bytes into non-volatile storage.
- A reload of the stored bytes back into the scratchpad.

While a conversion or a copy runs, the block raises a strong-pullup enable so that the bus can carry the heavy supply current. At the end of each operation it gives a one-cycle done pulse to the sensor, storage and alarm logic. During a reload it supplies the bit that a read slot returns.

All timing is counted in microsecond ticks from an external tick strobe. The full 12-bit conversion time, the copy time and the reload time are parameters, so a simulation can use short windows. Only one operation runs at a time. A command byte that arrives while an operation is running is dropped, and the block pulses an error strobe.

Top module: `thermo_op_sequencer`

## Requirements
- R1: After reset the block is idle: all busy outputs, done pulses, `pullup_en` and `cmd_reject` are 0, and `recall_bit` is 1.
- R2: When code 0x44 is accepted in idle, `conv_busy` and `pullup_en` are 1 from the cycle after the strobe.
- R3: A conversion lasts CONV_FULL_US/8, /4, /2 or /1 ticks when `res_sel` is 00, 01, 10 or 11 respectively. The tick count starts after the accepting cycle.
- R4: When code 0x48 is accepted in idle, the copy lasts COPY_US ticks, and `copy_busy` and `pullup_en` stay 1 for that whole time.
- R5: `pullup_en` is 1 exactly while `conv_busy` or `copy_busy` is 1. It is 0 in idle and during a reload.
- R6: `conv_done` and `copy_done` are single-cycle pulses. Each falls in the first cycle after the final counted tick, the same cycle in which the matching busy output falls.
- R7: When code 0xB8 is accepted in idle, `recall_busy` is 1 for RECALL_US ticks and `recall_bit` reads 0 during that time and 1 otherwise. `recall_done` pulses once at the end.
- R8: A valid strobe while any operation runs is ignored. `cmd_reject` pulses for one cycle after it, and the running operation keeps its length.
- R9: Any code other than 0x44, 0x48 or 0xB8 received in idle starts nothing and does not pulse `cmd_reject`.
- R10: At most one of the three busy outputs is 1 in any cycle.
- R11: The resolution is captured when a conversion is accepted. Changing `res_sel` while the conversion runs does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte | input | 8 | Received function-command byte |
| cmd_valid | input | 1 | One-cycle strobe marking `cmd_byte` valid |
| res_sel | input | 2 | Conversion resolution select (00 = 9-bit to 11 = 12-bit) |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| pullup_en | output | 1 | Strong-pullup enable |
| conv_busy | output | 1 | Temperature conversion running |
| conv_done | output | 1 | One-cycle pulse at the end of a conversion |
| copy_busy | output | 1 | Copy into storage running |
| copy_done | output | 1 | One-cycle pulse at the end of a copy |
| recall_busy | output | 1 | Reload from storage running |
| recall_done | output | 1 | One-cycle pulse at the end of a reload |
| recall_bit | output | 1 | Read-slot value: 0 during a reload, 1 otherwise |
| cmd_reject | output | 1 | One-cycle pulse when a command is dropped because an operation is running |

## Verification
The bench builds the block with CONV_FULL_US = 64, COPY_US = 10 and RECALL_US = 5, and a tick on every third clock. The four conversion lengths of 8, 16, 32 and 64 ticks, together with the copy and reload windows, then complete within a few hundred cycles. This lets a single run cover every resolution and each tick-boundary end. It also reaches a rejected command that lands in the middle of a window and a resolution change during a conversion.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_CONV   = 2'd1,
        OP_COPY   = 2'd2,
        OP_RECALL = 2'd3
    } op_t;

    typedef struct packed {
        logic conv;
        logic copy;
        logic recall;
    } op_flags_t;

    localparam logic [7:0] CODE_CONVERT = 8'h44;
    localparam logic [7:0] CODE_COPY    = 8'h48;
    localparam logic [7:0] CODE_RECALL  = 8'hB8;

    function automatic op_t classify(input logic [7:0] code);
        case (code)
            CODE_CONVERT: return OP_CONV;
            CODE_COPY:    return OP_COPY;
            CODE_RECALL:  return OP_RECALL;
            default:      return OP_NONE;
        endcase
    endfunction

    // Conversion length in ticks: full 12-bit time halved per dropped bit.
    function automatic int unsigned conv_ticks(input int unsigned full, input logic [1:0] res);
        case (res)
            2'b00:   return full >> 3;
            2'b01:   return full >> 2;
            2'b10:   return full >> 1;
            default: return full;
        endcase
    endfunction

endpackage

// File: rtl/tseq_decode.sv
module tseq_decode
    import tseq_pkg::*;
(
    input  logic [7:0] code,
    output op_t        op
);
    assign op = classify(code);
endmodule

// File: rtl/tseq_timer.sv
module tseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    assign expire = run && tick && (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || load)
            cnt <= '0;
        else if (run && tick)
            cnt <= expire ? '0 : cnt + CW'(1);
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < limit)); // R3

endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
    import tseq_pkg::*;
#(
    parameter int CW           = 8,
    parameter int CONV_FULL_US = 750000,
    parameter int COPY_US      = 10000,
    parameter int RECALL_US    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  op_t           req_op,
    input  logic [1:0]    res_sel,
    input  logic          expire,
    output op_t           cur_op,
    output logic          start,
    output logic [CW-1:0] limit,
    output op_flags_t     done,
    output logic          reject
);
    logic [CW-1:0] next_len;

    assign start = cmd_valid && (cur_op == OP_NONE) && (req_op != OP_NONE);

    always_comb begin
        case (req_op)
            OP_CONV:   next_len = CW'(conv_ticks(CONV_FULL_US, res_sel));
            OP_COPY:   next_len = CW'(COPY_US);
            OP_RECALL: next_len = CW'(RECALL_US);
            default:   next_len = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_op <= OP_NONE;
            limit  <= '0;
            done   <= '0;
            reject <= 1'b0;
        end else begin
            done   <= '0;
            reject <= 1'b0;
            if (cur_op != OP_NONE) begin
                if (cmd_valid)
                    reject <= 1'b1;
                if (expire) begin
                    cur_op      <= OP_NONE;
                    done.conv   <= (cur_op == OP_CONV);
                    done.copy   <= (cur_op == OP_COPY);
                    done.recall <= (cur_op == OP_RECALL);
                end
            end else if (start) begin
                cur_op <= req_op;
                limit  <= next_len;
            end
        end
    end

    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (cur_op != OP_NONE) |=> $stable(limit)); // R11

    AST_DONE_ONLY_WHEN_RUNNING: assert property (@(posedge clk) disable iff (rst)
        (done != '0) |-> $past(cur_op != OP_NONE)); // R6

endmodule

// File: rtl/thermo_op_sequencer.sv
module thermo_op_sequencer
    import tseq_pkg::*;
#(
    parameter int CONV_FULL_US = 750000,
    parameter int COPY_US      = 10000,
    parameter int RECALL_US    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_valid,
    input  logic [1:0] res_sel,
    input  logic       us_tick,
    output logic       pullup_en,
    output logic       conv_busy,
    output logic       conv_done,
    output logic       copy_busy,
    output logic       copy_done,
    output logic       recall_busy,
    output logic       recall_done,
    output logic       recall_bit,
    output logic       cmd_reject
);
    localparam int MAX_A = (CONV_FULL_US > COPY_US) ? CONV_FULL_US : COPY_US;
    localparam int MAX_T = (MAX_A > RECALL_US) ? MAX_A : RECALL_US;
    localparam int CW    = $clog2(MAX_T + 1);

    op_t           req_op;
    op_t           cur_op;
    logic          start;
    logic          expire;
    logic [CW-1:0] limit;
    op_flags_t     done;
    logic          busy_any;

    tseq_decode u_dec (
        .code (cmd_byte),
        .op   (req_op)
    );

    tseq_ctrl #(
        .CW           (CW),
        .CONV_FULL_US (CONV_FULL_US),
        .COPY_US      (COPY_US),
        .RECALL_US    (RECALL_US)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .req_op    (req_op),
        .res_sel   (res_sel),
        .expire    (expire),
        .cur_op    (cur_op),
        .start     (start),
        .limit     (limit),
        .done      (done),
        .reject    (cmd_reject)
    );

    tseq_timer #(
        .CW (CW)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .run    (busy_any),
        .tick   (us_tick),
        .limit  (limit),
        .expire (expire)
    );

    assign busy_any    = (cur_op != OP_NONE);
    assign conv_busy   = (cur_op == OP_CONV);
    assign copy_busy   = (cur_op == OP_COPY);
    assign recall_busy = (cur_op == OP_RECALL);
    assign pullup_en   = conv_busy || copy_busy;
    assign recall_bit  = !recall_busy;
    assign conv_done   = done.conv;
    assign copy_done   = done.copy;
    assign recall_done = done.recall;

    AST_PULLUP_ON_START: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy_any && (cmd_byte == CODE_CONVERT || cmd_byte == CODE_COPY))
        |=> pullup_en); // R2

    AST_REJECT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy_any) |=> cmd_reject); // R8

    AST_NO_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy_any) |=> !cmd_reject); // R9

    AST_CONV_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> ($past(conv_busy) && !conv_busy)); // R6

    AST_RECALL_NO_PULLUP: assert property (@(posedge clk) disable iff (rst)
        recall_busy |-> !pullup_en); // R5

    AST_SINGLE_OP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({conv_busy, copy_busy, recall_busy})); // R10

endmodule

// File: tb/sim_thermo_op_sequencer.sv
module sim_thermo_op_sequencer;

    localparam int CONV_FULL = 64;
    localparam int COPY_T    = 10;
    localparam int RECALL_T  = 5;

    typedef struct {
        int kind;   // 1 conversion, 2 copy, 3 reload
        int ticks;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd_byte = 8'h00;
    logic       cmd_valid = 1'b0;
    logic [1:0] res_sel = 2'b11;
    logic       us_tick = 1'b0;
    logic       pullup_en, conv_busy, conv_done, copy_busy, copy_done;
    logic       recall_busy, recall_done, recall_bit, cmd_reject;

    int checks = 0;
    int errors = 0;
    int seen_ticks = 0;
    exp_t expq[$];

    always #4 clk = ~clk;

    thermo_op_sequencer #(
        .CONV_FULL_US (CONV_FULL),
        .COPY_US      (COPY_T),
        .RECALL_US    (RECALL_T)
    ) u0 (
        .clk (clk), .rst (rst), .cmd_byte (cmd_byte), .cmd_valid (cmd_valid),
        .res_sel (res_sel), .us_tick (us_tick), .pullup_en (pullup_en),
        .conv_busy (conv_busy), .conv_done (conv_done), .copy_busy (copy_busy),
        .copy_done (copy_done), .recall_busy (recall_busy), .recall_done (recall_done),
        .recall_bit (recall_bit), .cmd_reject (cmd_reject)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // tick generator: one tick every third clock, driven after the edge
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #2;
            us_tick = (ph == 2);
            ph = (ph == 2) ? 0 : ph + 1;
        end
    end

    // monitor and scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if ((conv_busy || copy_busy || recall_busy) && us_tick)
                seen_ticks++;
            check("R5 pullup_en tracks conv/copy", pullup_en, conv_busy || copy_busy);
            check("R7 recall_bit", recall_bit, !recall_busy);
            check("R10 one op", int'(conv_busy) + int'(copy_busy) + int'(recall_busy) <= 1, 1);
            if (conv_done || copy_done || recall_done) begin
                exp_t e;
                int kind;
                kind = conv_done ? 1 : (copy_done ? 2 : 3);
                check("R6 busy low with done", int'(conv_busy || copy_busy || recall_busy), 0);
                if (expq.size() == 0) begin
                    check("R6 unexpected done", kind, 0);
                end else begin
                    e = expq.pop_front();
                    check("R6 done kind", kind, e.kind);
                    if (e.kind == 1) check("R3 R11 conversion ticks", seen_ticks, e.ticks);
                    if (e.kind == 2) check("R4 copy ticks", seen_ticks, e.ticks);
                    if (e.kind == 3) check("R7 reload ticks", seen_ticks, e.ticks);
                end
                seen_ticks = 0;
            end
        end
    end

    task automatic send(input logic [7:0] code);
        @(posedge clk); #2;
        cmd_byte  = code;
        cmd_valid = 1'b1;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (conv_busy || copy_busy || recall_busy);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_conv(input logic [1:0] res);
        exp_t e;
        res_sel = res;
        e.kind = 1;
        e.ticks = CONV_FULL >> (3 - int'(res));
        expq.push_back(e);
        send(8'h44);
        @(negedge clk);
        check("R2 conv_busy after 0x44", conv_busy, 1);
        check("R2 pullup_en after 0x44", pullup_en, 1);
        wait_idle();
    endtask

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check("R1 conv_busy", conv_busy, 0);
        check("R1 copy_busy", copy_busy, 0);
        check("R1 recall_busy", recall_busy, 0);
        check("R1 pullup_en", pullup_en, 0);
        check("R1 cmd_reject", cmd_reject, 0);
        check("R1 recall_bit", recall_bit, 1);

        for (int r = 0; r < 4; r++) run_conv(2'(r));

        // R11: resolution change during a 9-bit conversion
        res_sel = 2'b00;
        e.kind = 1; e.ticks = CONV_FULL >> 3;
        expq.push_back(e);
        send(8'h44);
        #1 res_sel = 2'b11;
        wait_idle();

        // R4: copy
        e.kind = 2; e.ticks = COPY_T;
        expq.push_back(e);
        send(8'h48);
        @(negedge clk);
        check("R4 copy_busy", copy_busy, 1);
        check("R4 pullup_en", pullup_en, 1);
        wait_idle();

        // R7: reload
        e.kind = 3; e.ticks = RECALL_T;
        expq.push_back(e);
        send(8'hB8);
        @(negedge clk);
        check("R7 recall_bit low", recall_bit, 0);
        check("R5 no pullup in reload", pullup_en, 0);
        wait_idle();

        // R8: command during a conversion is rejected, length unchanged
        res_sel = 2'b01;
        e.kind = 1; e.ticks = CONV_FULL >> 2;
        expq.push_back(e);
        send(8'h44);
        repeat (5) @(posedge clk);
        send(8'h48);
        @(negedge clk);
        check("R8 cmd_reject pulse", cmd_reject, 1);
        check("R8 still converting", conv_busy, 1);
        @(negedge clk);
        check("R8 reject one cycle", cmd_reject, 0);
        check("R8 copy not started", copy_busy, 0);
        wait_idle();

        // R9: unknown code in idle
        send(8'hBE);
        @(negedge clk);
        check("R9 no reject", cmd_reject, 0);
        check("R9 no op", int'(conv_busy || copy_busy || recall_busy), 0);
        repeat (4) @(negedge clk);

        check("R6 all ops completed", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule